// File: doc/BRIEF.md
# Divider Pair Search Engine

This block searches for the settings of two cascaded integer clock dividers that bring a source frequency as close as possible to a requested frequency. The first stage divides by 1 to 8 and the second stage divides by 1 to 64. Both the source frequency and the requested frequency are 32-bit unsigned numbers.

The engine checks every one of the 512 combinations, one per clock cycle. The first-stage divisor is the outer loop and the second-stage divisor is the inner loop. Software or a sequencer pulses `start`. Both operands are captured on that edge. `busy` then stays high while the sweep runs. When the sweep ends, `done` pulses for one cycle and the result is presented on registered outputs. The result has three parts: the chosen divisors, the divisors encoded as value-minus-one fields, and the achieved frequency rounded upward through both stages.

The interface uses plain control pins with no back-pressure. The operands only need to be valid on the cycle that `start` is sampled. The result stays on the outputs until the next search completes, so there is no ready signal.

Top module: `divpair_search`

## Requirements
- R1: After reset, `busy` and `done` are low, `pre_sel` and `post_sel` are 1, both code outputs are 0 and `rate_out` is 0.
- R2: The reported pair (p, q) gives the smallest value of |floor(floor(P/p)/q) − T| over p in 1..8 and q in 1..64, where P is the captured source value and T is the captured target value. The difference is formed without wrap-around for every 32-bit P and T.
- R3: Candidates are visited with p as the outer loop and q as the inner loop, both in ascending order. A later candidate replaces the best pair only when its error is strictly smaller, so on a tie the earliest pair is kept.
- R4: `pre_code` equals p − 1 in 3 bits and `post_code` equals q − 1 in 6 bits.
- R5: `rate_out` equals ceil(ceil(P/p)/q) for the reported pair.
- R6: Call the rising edge that samples `start` edge 0. Then `busy` is high from edge 0 until edge 513, and `done` is high for exactly one cycle after edge 513, with `busy` low at that point.
- R7: A `start` pulse while `busy` is high is ignored. The running search keeps the operands captured at its own start.
- R8: All result outputs keep their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled only while idle |
| parent_rate | input | 32 | Source frequency, captured with start |
| target_rate | input | 32 | Requested frequency, captured with start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| pre_sel | output | 4 | Chosen first-stage divisor, 1..8 |
| post_sel | output | 7 | Chosen second-stage divisor, 1..64 |
| pre_code | output | 3 | pre_sel − 1 |
| post_code | output | 6 | post_sel − 1 |
| rate_out | output | 32 | Achieved frequency, rounded up through both stages |

## Verification
The bench targets several corner cases:
- A zero target, a target above the source, a zero source and all-ones operands. A design that formed the error in 32 bits would wrap the difference on these and pick a far-off pair.
- Sources with many equal-error pairs. A design that replaced the best pair on equal error would report the last pair instead of the first.
- A non-exact source, where a design that truncated instead of rounding up would report a lower achieved frequency.
- A second start in the middle of a search, and counting edges up to done. These expose a design that restarts the search or is off by one cycle in latency.

// File: rtl/divpair_pkg.sv
package divpair_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } dp_state_e;
endpackage

// File: rtl/divpair_div.sv
// Combinational restoring divider: quotient and remainder of num / den.
module divpair_div #(
  parameter int NW = 32,
  parameter int DW = 7
) (
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic [NW-1:0] quo,
  output logic [DW-1:0] rem
);
  always_comb begin
    logic [DW:0] acc;
    acc = '0;
    quo = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      acc = {acc[DW-1:0], num[i]};
      if (acc >= {1'b0, den}) begin
        acc    = acc - {1'b0, den};
        quo[i] = 1'b1;
      end
    end
    rem = acc[DW-1:0];
  end
endmodule

// File: rtl/divpair_sweep.sv
// Nested candidate counter: outer pre index, inner post index.
module divpair_sweep #(
  parameter int PRE_MAX  = 8,
  parameter int POST_MAX = 64,
  localparam int PRE_W   = $clog2(PRE_MAX + 1),
  localparam int POST_W  = $clog2(POST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [PRE_W-1:0]  pre,
  output logic [POST_W-1:0] post,
  output logic              last_inner,
  output logic              last_all
);
  assign last_inner = (post == POST_W'(POST_MAX));
  assign last_all   = last_inner && (pre == PRE_W'(PRE_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= PRE_W'(1);
      post <= POST_W'(1);
    end else if (clr) begin
      pre  <= PRE_W'(1);
      post <= POST_W'(1);
    end else if (step) begin
      if (last_inner) begin
        post <= POST_W'(1);
        pre  <= pre + PRE_W'(1);
      end else begin
        post <= post + POST_W'(1);
      end
    end
  end

  // R3: inner index advances first, outer index holds
  p_inner_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && !last_inner) |=> (post == $past(post) + POST_W'(1)) && (pre == $past(pre)));

  // R3: inner wrap advances the outer index
  p_outer_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr && last_inner && !last_all) |=> (post == POST_W'(1)) && (pre == $past(pre) + PRE_W'(1)));

  // R2: stepping indices stay in range
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (pre >= PRE_W'(1)) && (pre <= PRE_W'(PRE_MAX)) &&
             (post >= POST_W'(1)) && (post <= POST_W'(POST_MAX)));
endmodule

// File: rtl/divpair_best.sv
// Holds the best pair and its absolute error; strict compare keeps ties.
module divpair_best #(
  parameter int RATE_W  = 32,
  parameter int PRE_W   = 4,
  parameter int POST_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [RATE_W:0]   cand_abs,
  input  logic [PRE_W-1:0]  cand_pre,
  input  logic [POST_W-1:0] cand_post,
  output logic [RATE_W:0]   best_abs,
  output logic [PRE_W-1:0]  best_pre,
  output logic [POST_W-1:0] best_post
);
  logic better;
  assign better = en && (cand_abs < best_abs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_abs  <= '1;
      best_pre  <= PRE_W'(1);
      best_post <= POST_W'(1);
    end else if (clr) begin
      best_abs  <= '1;
      best_pre  <= PRE_W'(1);
      best_post <= POST_W'(1);
    end else if (better) begin
      best_abs  <= cand_abs;
      best_pre  <= cand_pre;
      best_post <= cand_post;
    end
  end

  // R2: tracked error never grows during a sweep
  p_err_monotone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> best_abs <= $past(best_abs));

  // R3: an equal or worse candidate leaves the pair untouched
  p_tie_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr && cand_abs >= best_abs) |=> $stable(best_pre) && $stable(best_post));
endmodule

// File: rtl/divpair_search.sv
module divpair_search
  import divpair_pkg::*;
#(
  parameter int RATE_W     = 32,
  parameter int PRE_MAX    = 8,
  parameter int POST_MAX   = 64,
  parameter bit EXACT_STOP = 1'b0,
  localparam int PRE_W     = $clog2(PRE_MAX + 1),
  localparam int POST_W    = $clog2(POST_MAX + 1),
  localparam int PREC_W    = $clog2(PRE_MAX),
  localparam int POSTC_W   = $clog2(POST_MAX)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [RATE_W-1:0]  parent_rate,
  input  logic [RATE_W-1:0]  target_rate,
  output logic               busy,
  output logic               done,
  output logic [PRE_W-1:0]   pre_sel,
  output logic [POST_W-1:0]  post_sel,
  output logic [PREC_W-1:0]  pre_code,
  output logic [POSTC_W-1:0] post_code,
  output logic [RATE_W-1:0]  rate_out
);
  dp_state_e state;

  logic [RATE_W-1:0] par_q, req_q, pre_q;
  logic              launch, running, finishing;

  logic [PRE_W-1:0]  cur_pre;
  logic [POST_W-1:0] cur_post;
  logic              last_inner, last_all;

  logic [RATE_W:0]   best_abs;
  logic [PRE_W-1:0]  best_pre;
  logic [POST_W-1:0] best_post;

  assign launch    = (state == ST_IDLE) && start;
  assign running   = (state == ST_RUN);
  assign finishing = (state == ST_FIN);
  assign busy      = (state != ST_IDLE);

  divpair_sweep #(.PRE_MAX(PRE_MAX), .POST_MAX(POST_MAX)) u_sweep (
    .clk(clk), .rst_n(rst_n), .clr(launch), .step(running),
    .pre(cur_pre), .post(cur_post),
    .last_inner(last_inner), .last_all(last_all)
  );

  // First stage: next pre-quotient while running, ceil of P/p while finishing.
  logic [PRE_W-1:0]  pd_den;
  logic [RATE_W-1:0] pd_quo;
  logic [PRE_W-1:0]  pd_rem;
  assign pd_den = finishing ? best_pre : (cur_pre + PRE_W'(1));

  divpair_div #(.NW(RATE_W), .DW(PRE_W)) u_pre_div (
    .num(par_q), .den(pd_den), .quo(pd_quo), .rem(pd_rem)
  );

  logic [RATE_W-1:0] ceil_pre;
  assign ceil_pre = pd_quo + RATE_W'(pd_rem != '0);

  // Second stage: candidate rate while running, ceil of the rounded value while finishing.
  logic [RATE_W-1:0] qd_num, qd_quo;
  logic [POST_W-1:0] qd_den, qd_rem;
  assign qd_num = finishing ? ceil_pre : pre_q;
  assign qd_den = finishing ? best_post : cur_post;

  divpair_div #(.NW(RATE_W), .DW(POST_W)) u_post_div (
    .num(qd_num), .den(qd_den), .quo(qd_quo), .rem(qd_rem)
  );

  logic [RATE_W-1:0] ceil_post;
  assign ceil_post = qd_quo + RATE_W'(qd_rem != '0);

  // Signed error with one guard bit, then magnitude.
  logic signed [RATE_W:0] diff;
  logic        [RATE_W:0] diff_abs;
  assign diff     = $signed({1'b0, qd_quo}) - $signed({1'b0, req_q});
  assign diff_abs = diff[RATE_W] ? $unsigned(-diff) : $unsigned(diff);

  divpair_best #(.RATE_W(RATE_W), .PRE_W(PRE_W), .POST_W(POST_W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(launch), .en(running),
    .cand_abs(diff_abs), .cand_pre(cur_pre), .cand_post(cur_post),
    .best_abs(best_abs), .best_pre(best_pre), .best_post(best_post)
  );

  logic stop_now;
  generate
    if (EXACT_STOP) begin : g_exact
      assign stop_now = last_all || (diff_abs == '0);
    end else begin : g_full
      assign stop_now = last_all;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      par_q     <= '0;
      req_q     <= '0;
      pre_q     <= '0;
      pre_sel   <= PRE_W'(1);
      post_sel  <= POST_W'(1);
      pre_code  <= '0;
      post_code <= '0;
      rate_out  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            par_q <= parent_rate;
            req_q <= target_rate;
            pre_q <= parent_rate;
            state <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (last_inner) pre_q <= pd_quo;
          if (stop_now) state <= ST_FIN;
        end
        ST_FIN: begin
          pre_sel   <= best_pre;
          post_sel  <= best_post;
          pre_code  <= PREC_W'(best_pre - PRE_W'(1));
          post_code <= POSTC_W'(best_post - POST_W'(1));
          rate_out  <= ceil_post;
          done      <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: completion is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: done never overlaps busy
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7: captured operands are frozen during a search
  p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(par_q) && $stable(req_q));

  // R8: results only move together with done
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rate_out) || done);

  // R4: code fields track the selected divisors
  p_codes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pre_code == PREC_W'(pre_sel - PRE_W'(1))) &&
             (post_code == POSTC_W'(post_sel - POST_W'(1))));
endmodule

// File: tb/divpair_search_test.sv
module divpair_search_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parent_rate = '0;
  logic [31:0] target_rate = '0;
  logic        busy, done;
  logic [3:0]  pre_sel;
  logic [6:0]  post_sel;
  logic [2:0]  pre_code;
  logic [5:0]  post_code;
  logic [31:0] rate_out;

  int tests = 0;
  int fails = 0;

  // start edge counts as 1; 512 candidate edges; 1 finishing edge
  localparam int LAT = 514;

  always #5 clk = ~clk;

  divpair_search uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .parent_rate(parent_rate), .target_rate(target_rate),
    .busy(busy), .done(done), .pre_sel(pre_sel), .post_sel(post_sel),
    .pre_code(pre_code), .post_code(post_code), .rate_out(rate_out)
  );

  localparam logic [63:0] VECS [0:8] = '{
    {32'd24000000, 32'd1000000},
    {32'd100,      32'd3},
    {32'd1000,     32'd0},
    {32'd5000,     32'hFFFFFFFF},
    {32'hFFFFFFFF, 32'd0},
    {32'hFFFFFFFF, 32'hFFFFFFFF},
    {32'd7,        32'd2},
    {32'd0,        32'd5},
    {32'd800000000, 32'd3333333}
  };

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model(input longint P, input longint T,
                       output longint bp, output longint bq, output longint rate);
    longint best_err;
    best_err = 64'h7FFFFFFFFFFFFFFF;
    bp = 1; bq = 1;
    for (longint p = 1; p <= 8; p++) begin
      for (longint q = 1; q <= 64; q++) begin
        longint c, e;
        c = (P / p) / q;
        e = (c > T) ? c - T : T - c;
        if (e < best_err) begin
          best_err = e; bp = p; bq = q;
        end
      end
    end
    rate = (((P + bp - 1) / bp) + bq - 1) / bq;
  endtask

  // Launch a search, optionally pulse a second start mid-run, then check results.
  task automatic run(input logic [31:0] P, input logic [31:0] T, input bit poke);
    longint ep, eq, er;
    int cnt;
    bit busy_ok;
    model(P, T, ep, eq, er);
    @(negedge clk);
    parent_rate = P; target_rate = T; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    cnt = 1;
    busy_ok = 1'b1;
    while (!done && cnt < 2000) begin
      if (!busy) busy_ok = 1'b0;
      if (poke && cnt == 100) begin
        parent_rate = 32'd12345; target_rate = 32'd7; start = 1'b1;
      end else begin
        start = 1'b0;
        parent_rate = ~P; target_rate = ~T;
      end
      @(posedge clk);
      cnt++;
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == LAT, "R6 latency", cnt, LAT);
    check(busy_ok, "R6 busy during sweep", busy_ok, 1);
    check(!busy, "R6 busy low with done", busy, 0);
    check(pre_sel == ep, poke ? "R7 pre_sel" : "R2 pre_sel", pre_sel, ep);
    check(post_sel == eq, poke ? "R7 post_sel" : "R3 post_sel", post_sel, eq);
    check(pre_code == ep - 1, "R4 pre_code", pre_code, ep - 1);
    check(post_code == eq - 1, "R4 post_code", post_code, eq - 1);
    check(rate_out == er, "R5 rate_out", rate_out, er);
    @(negedge clk);
    check(!done, "R6 done one cycle", done, 0);
  endtask

  initial begin
    for (int w = 0; w < 150000; w++) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy, "R1 busy", busy, 0);
    check(!done, "R1 done", done, 0);
    check(pre_sel == 4'd1, "R1 pre_sel", pre_sel, 1);
    check(post_sel == 7'd1, "R1 post_sel", post_sel, 1);
    check(pre_code == 3'd0 && post_code == 6'd0, "R1 codes", {pre_code, post_code}, 0);
    check(rate_out == 32'd0, "R1 rate_out", rate_out, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 9; i++) begin
      run(VECS[i][63:32], VECS[i][31:0], 1'b0);
    end

    // R7: a second start during the sweep does not restart or retarget it
    run(32'd24000000, 32'd1000000, 1'b1);

    // R8: results hold with no new start
    begin
      logic [31:0] r0;
      logic [3:0]  p0;
      logic [6:0]  q0;
      r0 = rate_out; p0 = pre_sel; q0 = post_sel;
      parent_rate = 32'd99; target_rate = 32'd1;
      repeat (20) @(negedge clk);
      check(rate_out == r0, "R8 rate hold", rate_out, r0);
      check(pre_sel == p0 && post_sel == q0, "R8 pair hold", {pre_sel, post_sel}, {p0, q0});
      check(!busy, "R8 idle without start", busy, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule